// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block sits at the front of a pipelined processor for a small 64-bit instruction set whose instructions are 1, 2, 9 or 10 bytes long. It first picks the address to fetch from. A jump that was predicted taken but turned out not taken in the memory stage has the highest priority. A return that has read its target in write-back comes next. Otherwise the predicted PC is used. The instruction memory returns a window of bytes starting at that address, and the block splits the first byte into an instruction code (high nibble) and a function code (low nibble).

From the instruction code the block decides whether a register-specifier byte and a little-endian constant word are present. It extracts the two register fields and the constant, and computes the fall-through address. It predicts every jump and call as taken, so the next PC is the constant for those two and the fall-through address for all other instructions. It also produces a status code for the fetched instruction. The block is purely combinational. Its PC-select output drives the external instruction memory, and the predicted-PC output feeds an external register.

Top module: `fetch_unit`

## Requirements
- R1: `icode_o` equals bits 7:4 of window byte 0 and `ifun_o` equals bits 3:0. Window byte k occupies bits 8k+7:8k of `win_i`.
- R2: A register byte is present for codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. When it is present, `ra_o` is bits 7:4 and `rb_o` is bits 3:0 of window byte 1. When it is absent, both outputs are 0xF.
- R3: A constant word is present for codes 0x3, 0x4, 0x5, 0x7 and 0x8. `valc_o` is the WORD_W/8 bytes that start at byte 2 if a register byte is present and at byte 1 otherwise, assembled least significant byte first.
- R4: `valp_o` equals the fetch PC + 1, plus 1 if a register byte is present, plus WORD_W/8 if a constant is present. The sum wraps modulo 2^WORD_W.
- R5: `pred_pc_o` equals `valc_o` for codes 0x7 (jump) and 0x8 (call), and equals `valp_o` for every other code.
- R6: `fetch_pc_o` is `mem_vala_i` when `mem_icode_i` is 0x7 and `mem_cnd_i` is 0. Otherwise it is `wb_valm_i` when `wb_icode_i` is 0x9 (return). Otherwise it is `pred_pc_i`. The mispredict case wins when both the mispredict and return conditions hold.
- R7: `stat_o` is 3 when `imem_err_i` is set. Otherwise it is 4 for an invalid instruction. Otherwise it is 2 for code 0x0 (halt), and otherwise it is 1.
- R8: For code 0x6 a function value above 3 is invalid. For codes 0x2 and 0x7 a function value above 6 is invalid. For every other code the function value has no effect on `stat_o`.
- R9: Codes 0xC to 0xF are invalid, and they are treated as having neither a register byte nor a constant, so `valp_o` is the fetch PC + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| win_i | input | (WORD_W/8+2)*8 | Instruction bytes read at `fetch_pc_o`, byte 0 in the low bits |
| imem_err_i | input | 1 | Instruction memory reported a bad address |
| pred_pc_i | input | WORD_W | Predicted PC register value |
| mem_icode_i | input | 4 | Instruction code in the memory stage |
| mem_cnd_i | input | 1 | Branch condition outcome in the memory stage |
| mem_vala_i | input | WORD_W | Saved fall-through address in the memory stage |
| wb_icode_i | input | 4 | Instruction code in write-back |
| wb_valm_i | input | WORD_W | Value read from memory by the write-back instruction |
| fetch_pc_o | output | WORD_W | Address to fetch from this cycle |
| icode_o | output | 4 | Instruction code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| valc_o | output | WORD_W | Constant word |
| valp_o | output | WORD_W | Fall-through address |
| pred_pc_o | output | WORD_W | Predicted next PC |
| stat_o | output | 3 | Fetch status code |

## Verification
The bench builds the block with its default WORD_W of 64, which gives a 10-byte window. This makes all four instruction lengths reachable, as well as both constant offsets and every byte lane of the constant. Random 64-bit PCs and feedback values include addresses near the top of the space, so the fall-through sum is exercised across the carry. Directed cases pair mispredict and return feedback to show the select priority, and they probe each function-code range edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam logic [3:0] IC_HALT  = 4'h0;
    localparam logic [3:0] IC_NOP   = 4'h1;
    localparam logic [3:0] IC_RRMOV = 4'h2;
    localparam logic [3:0] IC_IRMOV = 4'h3;
    localparam logic [3:0] IC_RMMOV = 4'h4;
    localparam logic [3:0] IC_MRMOV = 4'h5;
    localparam logic [3:0] IC_ALU   = 4'h6;
    localparam logic [3:0] IC_JUMP  = 4'h7;
    localparam logic [3:0] IC_CALL  = 4'h8;
    localparam logic [3:0] IC_RET   = 4'h9;
    localparam logic [3:0] IC_PUSH  = 4'hA;
    localparam logic [3:0] IC_POP   = 4'hB;

    localparam logic [3:0] REG_NONE    = 4'hF;
    localparam logic [3:0] ALU_FUN_MAX = 4'd3;
    localparam logic [3:0] CND_FUN_MAX = 4'd6;

    typedef enum logic [2:0] {
        FS_AOK = 3'd1,
        FS_HLT = 3'd2,
        FS_ADR = 3'd3,
        FS_INS = 3'd4
    } fstat_e;

    typedef struct packed {
        logic [3:0] code;
        logic [3:0] fun;
        logic       known;
        logic       fun_ok;
        logic       has_regs;
        logic       has_const;
        logic       to_const;
    } op_info_t;

    function automatic logic code_known(input logic [3:0] c);
        return c <= IC_POP;
    endfunction

    function automatic logic code_has_regs(input logic [3:0] c);
        case (c)
            IC_RRMOV, IC_IRMOV, IC_RMMOV, IC_MRMOV,
            IC_ALU, IC_PUSH, IC_POP: return 1'b1;
            default:                 return 1'b0;
        endcase
    endfunction

    function automatic logic code_has_const(input logic [3:0] c);
        case (c)
            IC_IRMOV, IC_RMMOV, IC_MRMOV,
            IC_JUMP, IC_CALL: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    function automatic logic fun_in_range(input logic [3:0] c, input logic [3:0] f);
        case (c)
            IC_ALU:            return f <= ALU_FUN_MAX;
            IC_RRMOV, IC_JUMP: return f <= CND_FUN_MAX;
            default:           return 1'b1;
        endcase
    endfunction

    function automatic logic code_predicts_const(input logic [3:0] c);
        return (c == IC_JUMP) || (c == IC_CALL);
    endfunction

endpackage

// File: rtl/fetch_classify.sv
module fetch_classify
    import fetch_pkg::*;
(
    input  logic [7:0] byte0_i,
    output op_info_t   info_o,
    output logic       valid_o
);

    always_comb begin
        info_o.code      = byte0_i[7:4];
        info_o.fun       = byte0_i[3:0];
        info_o.known     = code_known(byte0_i[7:4]);
        info_o.fun_ok    = fun_in_range(byte0_i[7:4], byte0_i[3:0]);
        info_o.has_regs  = code_has_regs(byte0_i[7:4]);
        info_o.has_const = code_has_const(byte0_i[7:4]);
        info_o.to_const  = code_predicts_const(byte0_i[7:4]);
    end

    assign valid_o = info_o.known && info_o.fun_ok;

    // R8 / R9 guards
    always_comb begin
        a_r8_alu_fun_range: assert (!(valid_o && byte0_i[7:4] == IC_ALU) || byte0_i[3:0] <= 4'd3)
            else $error("valid ALU op with function out of range");
        a_r9_unknown_code: assert (byte0_i[7:4] <= IC_POP ||
                                   (!valid_o && !info_o.has_regs && !info_o.has_const))
            else $error("unknown code treated as valid or with operand bytes");
    end

endmodule

// File: rtl/fetch_extract.sv
module fetch_extract
    import fetch_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int CBYTES = WORD_W / 8,
    localparam int TAIL_W = (CBYTES + 1) * 8
) (
    input  logic [TAIL_W-1:0] tail_i,
    input  logic              has_regs_i,
    output logic [3:0]        ra_o,
    output logic [3:0]        rb_o,
    output logic [WORD_W-1:0] valc_o
);

    // tail_i byte t is window byte t+1
    assign ra_o = has_regs_i ? tail_i[7:4] : REG_NONE;
    assign rb_o = has_regs_i ? tail_i[3:0] : REG_NONE;

    for (genvar j = 0; j < CBYTES; j++) begin : g_cbyte
        assign valc_o[8*j +: 8] = has_regs_i ? tail_i[8*(j+1) +: 8] : tail_i[8*j +: 8];
    end

    // R2 guard
    always_comb begin
        a_r2_none_regs: assert (has_regs_i || (ra_o == 4'hF && rb_o == 4'hF))
            else $error("register fields not 0xF without register byte");
    end

endmodule

// File: rtl/fetch_nextpc.sv
module fetch_nextpc #(
    parameter int WORD_W = 64,
    localparam int CBYTES = WORD_W / 8
) (
    input  logic [WORD_W-1:0] pc_i,
    input  logic              has_regs_i,
    input  logic              has_const_i,
    input  logic              to_const_i,
    input  logic [WORD_W-1:0] valc_i,
    output logic [WORD_W-1:0] valp_o,
    output logic [WORD_W-1:0] pred_o
);

    logic [WORD_W-1:0] len;

    always_comb begin
        len = WORD_W'(1);
        if (has_regs_i)  len = len + WORD_W'(1);
        if (has_const_i) len = len + WORD_W'(CBYTES);
    end

    assign valp_o = pc_i + len;
    assign pred_o = to_const_i ? valc_i : valp_o;

    // R4 / R5 guards
    always_comb begin
        a_r4_length_set: assert ((valp_o - pc_i) == WORD_W'(1) || (valp_o - pc_i) == WORD_W'(2) ||
                                 (valp_o - pc_i) == WORD_W'(CBYTES + 1) ||
                                 (valp_o - pc_i) == WORD_W'(CBYTES + 2))
            else $error("instruction length outside legal set");
        a_r5_pred_source: assert (pred_o == valc_i || pred_o == valp_o)
            else $error("prediction from neither constant nor fall-through");
    end

endmodule

// File: rtl/fetch_pcsel.sv
module fetch_pcsel
    import fetch_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [WORD_W-1:0] pred_pc_i,
    input  logic [3:0]        mem_icode_i,
    input  logic              mem_cnd_i,
    input  logic [WORD_W-1:0] mem_vala_i,
    input  logic [3:0]        wb_icode_i,
    input  logic [WORD_W-1:0] wb_valm_i,
    output logic [WORD_W-1:0] pc_o
);

    logic mispredict;
    logic ret_done;

    assign mispredict = (mem_icode_i == IC_JUMP) && !mem_cnd_i;
    assign ret_done   = (wb_icode_i == IC_RET);

    always_comb begin
        if (mispredict)    pc_o = mem_vala_i;
        else if (ret_done) pc_o = wb_valm_i;
        else               pc_o = pred_pc_i;
    end

    // R6 guard
    always_comb begin
        a_r6_recovery_first: assert (!(mem_icode_i == 4'h7 && !mem_cnd_i) || pc_o == mem_vala_i)
            else $error("mispredict recovery lost priority");
    end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [(WORD_W/8+2)*8-1:0] win_i,
    input  logic                      imem_err_i,
    input  logic [WORD_W-1:0]         pred_pc_i,
    input  logic [3:0]                mem_icode_i,
    input  logic                      mem_cnd_i,
    input  logic [WORD_W-1:0]         mem_vala_i,
    input  logic [3:0]                wb_icode_i,
    input  logic [WORD_W-1:0]         wb_valm_i,
    output logic [WORD_W-1:0]         fetch_pc_o,
    output logic [3:0]                icode_o,
    output logic [3:0]                ifun_o,
    output logic [3:0]                ra_o,
    output logic [3:0]                rb_o,
    output logic [WORD_W-1:0]         valc_o,
    output logic [WORD_W-1:0]         valp_o,
    output logic [WORD_W-1:0]         pred_pc_o,
    output logic [2:0]                stat_o
);

    localparam int WIN_W = (WORD_W / 8 + 2) * 8;

    op_info_t info;
    logic     valid;
    fstat_e   stat;

    fetch_pcsel #(.WORD_W(WORD_W)) pcsel_i (
        .pred_pc_i  (pred_pc_i),
        .mem_icode_i(mem_icode_i),
        .mem_cnd_i  (mem_cnd_i),
        .mem_vala_i (mem_vala_i),
        .wb_icode_i (wb_icode_i),
        .wb_valm_i  (wb_valm_i),
        .pc_o       (fetch_pc_o)
    );

    fetch_classify classify_i (
        .byte0_i(win_i[7:0]),
        .info_o (info),
        .valid_o(valid)
    );

    fetch_extract #(.WORD_W(WORD_W)) extract_i (
        .tail_i    (win_i[WIN_W-1:8]),
        .has_regs_i(info.has_regs),
        .ra_o      (ra_o),
        .rb_o      (rb_o),
        .valc_o    (valc_o)
    );

    fetch_nextpc #(.WORD_W(WORD_W)) nextpc_i (
        .pc_i       (fetch_pc_o),
        .has_regs_i (info.has_regs),
        .has_const_i(info.has_const),
        .to_const_i (info.to_const),
        .valc_i     (valc_o),
        .valp_o     (valp_o),
        .pred_o     (pred_pc_o)
    );

    always_comb begin
        if (imem_err_i)              stat = FS_ADR;
        else if (!valid)             stat = FS_INS;
        else if (info.code == IC_HALT) stat = FS_HLT;
        else                         stat = FS_AOK;
    end

    assign icode_o = info.code;
    assign ifun_o  = info.fun;
    assign stat_o  = stat;

    // R7 guard
    always_comb begin
        a_r7_adr_wins: assert (!imem_err_i || stat_o == 3'd3)
            else $error("memory error did not give address status");
        a_r7_legal_code: assert (stat_o >= 3'd1 && stat_o <= 3'd4)
            else $error("status outside encoding");
    end

endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb_top;

    localparam int WORD_W = 64;
    localparam int WIN_W  = (WORD_W / 8 + 2) * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [WIN_W-1:0]  win;
    logic              imem_err;
    logic [WORD_W-1:0] pred_pc, mem_vala, wb_valm;
    logic [3:0]        mem_icode, wb_icode;
    logic              mem_cnd;
    logic [WORD_W-1:0] fetch_pc, valc, valp, pred_next;
    logic [3:0]        icode, ifun, ra, rb;
    logic [2:0]        stat;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    fetch_unit #(.WORD_W(WORD_W)) dut_i (
        .win_i(win), .imem_err_i(imem_err), .pred_pc_i(pred_pc),
        .mem_icode_i(mem_icode), .mem_cnd_i(mem_cnd), .mem_vala_i(mem_vala),
        .wb_icode_i(wb_icode), .wb_valm_i(wb_valm),
        .fetch_pc_o(fetch_pc), .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
        .valc_o(valc), .valp_o(valp), .pred_pc_o(pred_next), .stat_o(stat)
    );

    function automatic bit m_regs(input logic [3:0] c);
        return c inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
    endfunction
    function automatic bit m_const(input logic [3:0] c);
        return c inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
    endfunction
    function automatic bit m_valid(input logic [3:0] c, input logic [3:0] f);
        if (c > 4'hB) return 0;
        if (c == 4'h6) return f <= 4'd3;
        if (c == 4'h2 || c == 4'h7) return f <= 4'd6;
        return 1;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic apply_and_check();
        logic [3:0] c, f;
        logic [WORD_W-1:0] e_pc, e_c, e_p;
        int off;
        @(negedge clk);
        #1;
        c = win[7:4];
        f = win[3:0];
        if (mem_icode == 4'h7 && !mem_cnd) e_pc = mem_vala;
        else if (wb_icode == 4'h9)         e_pc = wb_valm;
        else                               e_pc = pred_pc;
        off = m_regs(c) ? 2 : 1;
        for (int k = 0; k < WORD_W / 8; k++) e_c[8*k +: 8] = win[8*(off+k) +: 8];
        e_p = e_pc + 1 + (m_regs(c) ? 1 : 0) + (m_const(c) ? WORD_W / 8 : 0);
        chk("R6", "fetch_pc", fetch_pc, e_pc);
        chk("R1", "icode", WORD_W'(icode), WORD_W'(c));
        chk("R1", "ifun", WORD_W'(ifun), WORD_W'(f));
        chk("R2", "ra", WORD_W'(ra), WORD_W'(m_regs(c) ? win[15:12] : 4'hF));
        chk("R2", "rb", WORD_W'(rb), WORD_W'(m_regs(c) ? win[11:8] : 4'hF));
        if (m_const(c)) chk("R3", "valc", valc, e_c);
        chk("R4", "valp", valp, e_p);
        chk("R5", "pred", pred_next, (c == 4'h7 || c == 4'h8) ? e_c : e_p);
        chk(m_valid(c, f) ? "R7" : "R8", "stat", WORD_W'(stat),
            WORD_W'(imem_err ? 3'd3 : !m_valid(c, f) ? 3'd4 : (c == 4'h0) ? 3'd2 : 3'd1));
    endtask

    task automatic quiet_fb();
        imem_err = 0; mem_icode = 4'h1; mem_cnd = 1; wb_icode = 4'h1;
        mem_vala = '0; wb_valm = '0;
    endtask

    initial begin
        win = '0; pred_pc = '0;
        quiet_fb();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: halt at address 0
        @(negedge clk); #1;
        chk("R7", "idle stat halt", WORD_W'(stat), WORD_W'(3'd2));
        chk("R4", "idle valp", valp, 64'd1);
        // irmov-type with one register, constant after reg byte (R3)
        win = {64'h1122334455667788, 8'hF3, 8'h30}; pred_pc = 64'h100;
        apply_and_check();
        chk("R3", "irmov const", valc, 64'h1122334455667788);
        chk("R4", "irmov len 10", valp, 64'h10A);
        // jump: constant at byte 1, predicted taken (R5)
        win = {8'h00, 64'h0000_0000_0000_0400, 8'h70};
        apply_and_check();
        chk("R5", "jump pred", pred_next, 64'h400);
        chk("R4", "jump len 9", valp, 64'h109);
        // mispredict and return together: mispredict wins (R6)
        mem_icode = 4'h7; mem_cnd = 0; mem_vala = 64'hAAAA; wb_icode = 4'h9; wb_valm = 64'hBBBB;
        apply_and_check();
        chk("R6", "priority", fetch_pc, 64'hAAAA);
        mem_cnd = 1;
        apply_and_check();
        chk("R6", "ret select", fetch_pc, 64'hBBBB);
        quiet_fb();
        // function range edges (R8)
        win = {72'h0, 8'h63}; apply_and_check();
        chk("R8", "alu fun 3", WORD_W'(stat), WORD_W'(3'd1));
        win = {72'h0, 8'h64}; apply_and_check();
        chk("R8", "alu fun 4", WORD_W'(stat), WORD_W'(3'd4));
        win = {72'h0, 8'h76}; apply_and_check();
        win = {72'h0, 8'h27}; apply_and_check();
        chk("R8", "cmov fun 7", WORD_W'(stat), WORD_W'(3'd4));
        win = {72'h0, 8'h9F}; apply_and_check();
        chk("R8", "ret fun ignored", WORD_W'(stat), WORD_W'(3'd1));
        // unknown code (R9)
        win = {72'hFFFF, 8'hC0}; apply_and_check();
        chk("R9", "unknown stat", WORD_W'(stat), WORD_W'(3'd4));
        chk("R9", "unknown len", valp, pred_pc + 1);
        // memory error beats halt (R7)
        imem_err = 1; win = '0; apply_and_check();
        chk("R7", "adr over halt", WORD_W'(stat), WORD_W'(3'd3));
        imem_err = 0;
        // wrap of fall-through (R4)
        pred_pc = 64'hFFFF_FFFF_FFFF_FFFE; win = {72'h0, 8'hA0}; apply_and_check();
        chk("R4", "wrap", valp, 64'h0);
        // random
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] c;
            c = ($urandom() % 4 == 0) ? 4'($urandom()) : 4'($urandom() % 12);
            win = {r64(), 8'($urandom()), c, ($urandom() % 2 == 0) ? 4'($urandom() % 8) : 4'($urandom())};
            pred_pc   = r64();
            imem_err  = ($urandom() % 16) == 0;
            mem_icode = ($urandom() % 3 == 0) ? 4'h7 : 4'($urandom());
            mem_cnd   = 1'($urandom());
            mem_vala  = r64();
            wb_icode  = ($urandom() % 3 == 0) ? 4'h9 : 4'($urandom());
            wb_valm   = r64();
            apply_and_check();
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule